// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides which hardware thread of a multithreaded core is allowed to fetch. A fetch round starts with a pulse on `sel_go`. The selector then makes up to `MAX_PICKS` selection attempts, one attempt per clock. Each attempt produces a registered result one clock later: either a thread ID or a "no thread" answer. A round ends early when an attempt finds no eligible thread, or when a drain is pending.

A thread is a candidate only if its active bit is set and its 3-bit status code is one of three fetchable codes. The 3-bit policy input chooses how one candidate is picked from several:
- **Round-robin:** walks an ordered priority list. Only the chosen entry moves to the tail of the list.
- **Instruction-queue occupancy:** picks the candidate with the fewest entries in its instruction queue.
- **Load/store-queue occupancy:** picks the candidate with the fewest entries in its load/store queue.

The control is a two-state machine:
- **ST_IDLE:** waiting for a round.
- **ST_PICK:** one attempt per clock.

It has three transitions:
- **Launch (ST_IDLE to ST_PICK):** `sel_go` is high while the block is idle.
- **Continue (ST_PICK to ST_PICK):** a thread was found and attempts remain.
- **Finish (ST_PICK to ST_IDLE):** no thread was found (which includes the drain case), or the last attempt of the round was made.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its `thr_active` bit is 1 and its status code is 0 (running), 1 (idle) or 4 (cache fill complete). The codes 2, 3, 5, 6 and 7 are never eligible. Status code of thread t sits in `thr_status[3t+2:3t]`.
- R2: After reset the block is idle (`busy`=0, `res_vld`=0, `res_found`=0), and the round-robin list holds the thread IDs in ascending order.
- R3: With policy 1 (round-robin), the list is scanned from the head and the first eligible thread is chosen. Only that entry is moved to the tail; all other entries keep their relative order.
- R4: With policy 2, the eligible thread with the smallest `iq_occ` count is chosen; ties go to the lower thread ID. The count of thread t sits in `iq_occ[CNT_W*t +: CNT_W]`.
- R5: With policy 3, the eligible thread with the smallest `lsq_occ` count is chosen; ties go to the lower thread ID. The same field layout as R4 applies.
- R6: With more than one thread configured, policy 0 (single), policy 4 (branch count, reserved) and codes 5 to 7 answer "no thread".
- R7: An attempt that finds no thread returns `res_vld`=1 with `res_found`=0, ends the round at once, and no further result follows in that round.
- R8: `sel_go` in ST_IDLE starts a round. Attempt k (k=1..`MAX_PICKS`) is evaluated in the k-th clock after launch, and its result appears on the outputs for one clock after that edge. `busy` is 1 exactly while attempts remain.
- R9: When `drain_pend` is 1 during an attempt, the result is "no thread", the round ends, and the round-robin list is left unchanged.
- R10: `sel_go` while a round is in progress is ignored and does not start a further round.
- R11: With `NUM_THREADS`=1 the answer for every policy is thread 0 when thread 0 is eligible, and "no thread" otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_go | input | 1 | Starts a selection round when idle |
| policy | input | 3 | 0 single, 1 round-robin, 2 IQ count, 3 LSQ count, 4 branch count (reserved) |
| drain_pend | input | 1 | Drain in progress; suppresses selection |
| thr_active | input | NUM_THREADS | Active-thread mask |
| thr_status | input | 3*NUM_THREADS | Per-thread status codes |
| iq_occ | input | CNT_W*NUM_THREADS | Per-thread instruction-queue occupancy |
| lsq_occ | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| busy | output | 1 | High in ST_PICK |
| res_vld | output | 1 | A selection result is presented this cycle |
| res_found | output | 1 | The result names a thread (0 means none) |
| res_tid | output | TID_W | Selected thread ID, 0 when none |

## Verification
A corrupted round-robin list cannot be seen on its own. It shows up as a wrong `res_tid` on the next round-robin attempt, one clock after that attempt is evaluated. For this reason the tests chain rounds, so that each round's expected IDs depend on every earlier move of an entry to the tail. A state machine that stays in ST_PICK too long, or starts again on `sel_go` while busy, shows within one clock: `res_vld` pulses in a cycle where none is due. A wrong eligibility or queue-count decision is visible directly in the result of the same attempt.

// File: rtl/fts_pkg.sv
package fts_pkg;

    // Per-thread status codes
    localparam logic [2:0] TS_RUN    = 3'd0;
    localparam logic [2:0] TS_IDLE   = 3'd1;
    localparam logic [2:0] TS_SQUASH = 3'd2;
    localparam logic [2:0] TS_BLOCK  = 3'd3;
    localparam logic [2:0] TS_DONE   = 3'd4;
    localparam logic [2:0] TS_WRESP  = 3'd5;
    localparam logic [2:0] TS_WRETRY = 3'd6;

    // Policy codes
    localparam logic [2:0] POL_SINGLE = 3'd0;
    localparam logic [2:0] POL_RR     = 3'd1;
    localparam logic [2:0] POL_IQ     = 3'd2;
    localparam logic [2:0] POL_LSQ    = 3'd3;
    localparam logic [2:0] POL_BRANCH = 3'd4;

    localparam int STAT_W = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PICK = 1'b1
    } sel_state_e;

    function automatic logic stat_fetchable(input logic [2:0] s);
        return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_DONE);
    endfunction

endpackage

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    input  logic             take,
    output logic             found,
    output logic [TID_W-1:0] tid
);

    logic [TID_W-1:0] slot_q [N];
    logic [TID_W-1:0] hit_pos;
    logic [N-1:0]     seen;

    // First eligible entry from the head (position 0)
    always_comb begin
        found   = 1'b0;
        tid     = '0;
        hit_pos = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (elig[slot_q[p]]) begin
                found   = 1'b1;
                tid     = slot_q[p];
                hit_pos = TID_W'(p);
            end
        end
    end

    // Chosen entry goes to the tail, entries behind it close the gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                slot_q[p] <= TID_W'(p);
            end
        end else if (take && found) begin
            for (int p = 0; p < N - 1; p++) begin
                if (TID_W'(p) >= hit_pos) begin
                    slot_q[p] <= slot_q[p+1];
                end
            end
            slot_q[N-1] <= tid;
        end
    end

    always_comb begin
        seen = '0;
        for (int p = 0; p < N; p++) begin
            seen[slot_q[p]] = 1'b1;
        end
    end

    AST_LIST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {N{1'b1}}); // R3

    AST_UNTAKEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(found) || !$stable(elig)); // R9

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]       elig,
    input  logic [N*CNT_W-1:0] occ,
    output logic               found,
    output logic [TID_W-1:0]   tid
);

    logic [CNT_W-1:0] best;

    // Ascending scan with strict compare: ties keep the lower ID
    always_comb begin
        found = 1'b0;
        tid   = '0;
        best  = '0;
        for (int t = 0; t < N; t++) begin
            if (elig[t] && (!found || (occ[t*CNT_W +: CNT_W] < best))) begin
                found = 1'b1;
                best  = occ[t*CNT_W +: CNT_W];
                tid   = TID_W'(t);
            end
        end
    end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    parameter int MAX_PICKS   = 2,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_go,
    input  logic [2:0]                     policy,
    input  logic                           drain_pend,
    input  logic [NUM_THREADS-1:0]         thr_active,
    input  logic [NUM_THREADS*STAT_W-1:0]  thr_status,
    input  logic [NUM_THREADS*CNT_W-1:0]   iq_occ,
    input  logic [NUM_THREADS*CNT_W-1:0]   lsq_occ,
    output logic                           busy,
    output logic                           res_vld,
    output logic                           res_found,
    output logic [TID_W-1:0]               res_tid
);

    localparam int ATT_W = $clog2(MAX_PICKS + 1);

    sel_state_e       state_q, state_d;
    logic [ATT_W-1:0] att_q;
    logic             last_att;

    logic [NUM_THREADS-1:0] elig;
    logic                   rr_found, iq_found, lsq_found;
    logic [TID_W-1:0]       rr_tid, iq_tid, lsq_tid;
    logic                   rr_take;
    logic                   pick_found;
    logic [TID_W-1:0]       pick_tid;

    // Eligibility per thread
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_elig
        assign elig[g] = thr_active[g] && stat_fetchable(thr_status[g*STAT_W +: STAT_W]);
    end

    assign busy = (state_q == ST_PICK);

    if (NUM_THREADS > 1) begin : g_multi
        assign rr_take = busy && (policy == POL_RR) && !drain_pend;

        fts_rr_list #(.N(NUM_THREADS), .TID_W(TID_W)) u_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .elig  (elig),
            .take  (rr_take),
            .found (rr_found),
            .tid   (rr_tid)
        );

        fts_min_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_iq (
            .elig  (elig),
            .occ   (iq_occ),
            .found (iq_found),
            .tid   (iq_tid)
        );

        fts_min_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_lsq (
            .elig  (elig),
            .occ   (lsq_occ),
            .found (lsq_found),
            .tid   (lsq_tid)
        );
    end else begin : g_single
        assign rr_take   = 1'b0;
        assign rr_found  = 1'b0;
        assign rr_tid    = '0;
        assign iq_found  = 1'b0;
        assign iq_tid    = '0;
        assign lsq_found = 1'b0;
        assign lsq_tid   = '0;
    end

    // Policy decision for the current attempt
    always_comb begin
        pick_found = 1'b0;
        pick_tid   = '0;
        if (NUM_THREADS == 1) begin
            pick_found = elig[0];
        end else begin
            case (policy)
                POL_RR: begin
                    pick_found = rr_found;
                    pick_tid   = rr_tid;
                end
                POL_IQ: begin
                    pick_found = iq_found;
                    pick_tid   = iq_tid;
                end
                POL_LSQ: begin
                    pick_found = lsq_found;
                    pick_tid   = lsq_tid;
                end
                default: begin
                    pick_found = 1'b0;
                end
            endcase
        end
        if (drain_pend) begin
            pick_found = 1'b0;
        end
    end

    assign last_att = (att_q == ATT_W'(MAX_PICKS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_go) state_d = ST_PICK;
            ST_PICK: if (!pick_found || last_att) state_d = ST_IDLE;
        endcase
    end

    // State register and attempt counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            att_q   <= '0;
        end else begin
            state_q <= state_d;
            att_q   <= (state_d == ST_PICK && state_q == ST_PICK) ? att_q + 1'b1 : '0;
        end
    end

    // Registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld   <= 1'b0;
            res_found <= 1'b0;
            res_tid   <= '0;
        end else begin
            res_vld   <= busy;
            res_found <= busy && pick_found;
            res_tid   <= (busy && pick_found) ? pick_tid : '0;
        end
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_found |-> ((($past(elig) >> res_tid) & NUM_THREADS'(1)) != '0)); // R1

    AST_RESULT_AFTER_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(busy)); // R8

    AST_ATTEMPT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(att_q) < MAX_PICKS)); // R8

    AST_NONE_ENDS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_found) |-> !busy); // R7

    AST_DRAIN_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drain_pend) |=> (res_vld && !res_found)); // R9

    AST_POLICY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((NUM_THREADS > 1) && busy && (policy == POL_SINGLE || policy >= POL_BRANCH))
        |=> !res_found); // R6

endmodule

// File: tb/fetch_thread_sel_tb_top.sv
module fetch_thread_sel_tb_top;
    import fts_pkg::*;

    localparam int NT = 4;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_go = 1'b0;
    logic [2:0] policy = POL_RR;
    logic drain_pend = 1'b0;
    logic [NT-1:0] thr_active = '1;
    logic [NT*3-1:0] thr_status = '0;
    logic [NT*CW-1:0] iq_occ = '0;
    logic [NT*CW-1:0] lsq_occ = '0;
    logic busy, res_vld, res_found;
    logic [1:0] res_tid;

    logic go1 = 1'b0;
    logic act1 = 1'b1;
    logic [2:0] stat1 = TS_RUN;
    logic busy1, vld1, found1;
    logic [0:0] tid1;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fetch_thread_sel #(.NUM_THREADS(NT), .CNT_W(CW), .MAX_PICKS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_go(sel_go), .policy(policy),
        .drain_pend(drain_pend), .thr_active(thr_active), .thr_status(thr_status),
        .iq_occ(iq_occ), .lsq_occ(lsq_occ), .busy(busy), .res_vld(res_vld),
        .res_found(res_found), .res_tid(res_tid)
    );

    fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(CW), .MAX_PICKS(2)) dut1_i (
        .clk(clk), .rst_n(rst_n), .sel_go(go1), .policy(policy),
        .drain_pend(1'b0), .thr_active(act1), .thr_status(stat1),
        .iq_occ(6'd0), .lsq_occ(6'd0), .busy(busy1), .res_vld(vld1),
        .res_found(found1), .res_tid(tid1)
    );

    task automatic chk(input string req, input string what, input integer act, input integer exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_stat(input logic [2:0] s0, input logic [2:0] s1,
                            input logic [2:0] s2, input logic [2:0] s3);
        thr_status = {s3, s2, s1, s0};
    endtask

    // One round; e0/e1 are expected thread IDs, -1 means "no thread"
    task automatic run_round(input string req, input integer e0, input integer e1,
                             input bit hold_go);
        @(negedge clk) sel_go = 1'b1;
        @(negedge clk) sel_go = hold_go;
        chk(req, "busy at launch", busy, 1);
        @(negedge clk) sel_go = 1'b0;
        chk(req, "first result valid", res_vld, 1);
        if (e0 < 0) begin
            chk(req, "first result none", res_found, 0);
            chk(req, "round ended on none", busy, 0);
        end else begin
            chk(req, "first found", res_found, 1);
            chk(req, "first tid", res_tid, e0);
            chk(req, "busy mid round", busy, 1);
            @(negedge clk);
            chk(req, "second result valid", res_vld, 1);
            if (e1 < 0) begin
                chk(req, "second none", res_found, 0);
            end else begin
                chk(req, "second found", res_found, 1);
                chk(req, "second tid", res_tid, e1);
            end
            chk(req, "busy after last attempt", busy, 0);
        end
        @(negedge clk);
        chk(req, "no result after round", res_vld, 0);
        chk(req, "still idle", busy, 0);
    endtask

    task automatic t_reset();
        chk("R2", "busy in reset", busy, 0);
        chk("R2", "res_vld in reset", res_vld, 0);
        chk("R2", "res_found in reset", res_found, 0);
    endtask

    task automatic t_rr_order();
        policy = POL_RR;
        set_stat(TS_RUN, TS_RUN, TS_RUN, TS_RUN);
        run_round("R2", 0, 1, 1'b0);
        run_round("R3", 2, 3, 1'b0);
    endtask

    task automatic t_rr_skip();
        set_stat(TS_BLOCK, TS_RUN, TS_RUN, TS_RUN);
        run_round("R3", 1, 2, 1'b0);
        set_stat(TS_RUN, TS_RUN, TS_RUN, TS_RUN);
        run_round("R3", 0, 3, 1'b0);
    endtask

    task automatic t_elig_codes();
        set_stat(TS_IDLE, TS_SQUASH, TS_DONE, TS_WRESP);
        run_round("R1", 2, 0, 1'b0);
        set_stat(TS_RUN, TS_RUN, TS_RUN, TS_RUN);
        thr_active = 4'b0010;
        run_round("R1", 1, 1, 1'b0);
        thr_active = 4'b1111;
        set_stat(TS_BLOCK, TS_WRETRY, 3'd7, TS_WRESP);
        run_round("R7", -1, -1, 1'b0);
    endtask

    task automatic t_iq();
        policy = POL_IQ;
        set_stat(TS_RUN, TS_RUN, TS_RUN, TS_RUN);
        iq_occ = {6'd9, 6'd3, 6'd3, 6'd5};
        run_round("R4", 1, 1, 1'b0);
        set_stat(TS_RUN, TS_BLOCK, TS_RUN, TS_RUN);
        run_round("R4", 2, 2, 1'b0);
    endtask

    task automatic t_lsq();
        policy = POL_LSQ;
        set_stat(TS_RUN, TS_RUN, TS_RUN, TS_RUN);
        iq_occ  = {6'd9, 6'd9, 6'd0, 6'd0};
        lsq_occ = {6'd1, 6'd1, 6'd6, 6'd4};
        run_round("R5", 2, 2, 1'b0);
    endtask

    task automatic t_policy_none();
        policy = POL_SINGLE;
        run_round("R6", -1, -1, 1'b0);
        policy = POL_BRANCH;
        run_round("R6", -1, -1, 1'b0);
        policy = 3'd7;
        run_round("R6", -1, -1, 1'b0);
    endtask

    task automatic t_drain();
        policy = POL_RR;
        drain_pend = 1'b1;
        run_round("R9", -1, -1, 1'b0);
        drain_pend = 1'b0;
        run_round("R9", 3, 2, 1'b0);
    endtask

    task automatic t_go_busy();
        run_round("R10", 0, 1, 1'b1);
    endtask

    task automatic t_one_thread(input string what, input integer exp_found);
        @(negedge clk) go1 = 1'b1;
        @(negedge clk) go1 = 1'b0;
        @(negedge clk);
        chk("R11", {what, " valid"}, vld1, 1);
        chk("R11", {what, " found"}, found1, exp_found);
        chk("R11", {what, " tid"}, tid1, 0);
        repeat (2) @(negedge clk);
        chk("R11", {what, " idle"}, busy1, 0);
    endtask

    task automatic t_single_cfg();
        policy = POL_RR;
        t_one_thread("rr", 1);
        policy = POL_BRANCH;
        t_one_thread("branch code", 1);
        stat1 = TS_BLOCK;
        t_one_thread("blocked", 0);
        stat1 = TS_RUN;
        act1 = 1'b0;
        t_one_thread("inactive", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rr_order();
        t_rr_skip();
        t_elig_codes();
        t_iq();
        t_lsq();
        t_policy_none();
        t_drain();
        t_go_busy();
        t_single_cfg();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule